// File: doc/BRIEF.md
# MRU-Flag Replacement Selector

This block keeps approximate recency for every set of a set-associative cache. Each set holds one "recently used" flag per way. When the cache controller reports a hit or finishes placing a line, it pulses an access strobe with the set index and the way. The block then marks that way as used. If every way of the set was already marked, the block first clears the whole set, so the history starts a new round.

For the set on the index input, the block shows the stored flags and a victim way. The victim is the lowest-numbered way that is not marked. It is recomputed combinationally from the stored flags, so the controller can read it in the same cycle it presents the index. Tag compare, data arrays and miss sequencing stay in the surrounding cache.

Top module: `mru_bit_replacer`

## Requirements
- R1: While reset is high, the flags of every set are cleared to 0, so after reset any set reads flags 0 and victim 0. Reset is synchronous and active high.
- R2: An access on set S and way W sets bit W of S's flags (bit i of `set_flags` belongs to way i). The other bits of S keep their values when S was not all ones.
- R3: If S's flags are all ones when an access arrives, S's flags become exactly the one-hot of W. If only some bits are set, no clear happens, even when the access makes the flags all ones.
- R4: `victim_way` is the lowest index i for which bit i of the selected set's flags is 0.
- R5: When the selected set's flags are all ones, `victim_way` is 0.
- R6: Outputs follow `set_idx` and the stored flags combinationally. An update becomes visible only after the rising clock edge that samples `acc_valid`.
- R7: An access to one set never changes the flags of any other set.
- R8: While `acc_valid` is low, no flags change, whatever `acc_way` holds.
- R9: With 8 ways, a set starting at 0 and filled at its victim eight times reads 8'hFF with victim 0. A ninth fill at the victim gives 8'h01 with victim 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_idx | input | $clog2(NUM_SETS) | Selected set for the read-out and for the update |
| acc_valid | input | 1 | Access or fill strobe, one update per cycle |
| acc_way | input | $clog2(NUM_WAYS) | Way that was accessed or filled |
| victim_way | output | $clog2(NUM_WAYS) | Lowest way of the selected set whose flag is clear |
| set_flags | output | NUM_WAYS | Stored flags of the selected set |

## Verification
The bench targets the wrap boundary from both sides. If a design wrapped one step early, the set would clear when the access that fills the last flag arrives. If it never wrapped, the set would stay all ones with victim 0 forever. It also re-hits a way that is already marked, which must leave the flags unchanged, and it wraps on a nonzero way, where a design that always restarts at way 0 fails. Finally it checks that a neighbouring set keeps its state across an update, that flags do not move while the strobe is low, and that the old flags are still visible before the clock edge, so a write that skips a cycle or leaks into another set shows up.

// File: rtl/mru_repl_pkg.sv
package mru_repl_pkg;
  localparam int unsigned DEF_WAYS = 8;
  localparam int unsigned DEF_SETS = 16;
endpackage

// File: rtl/mru_flag_store.sv
module mru_flag_store #(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SET_W-1:0]    addr,
  input  logic [NUM_WAYS-1:0] wr_data,
  output logic [NUM_WAYS-1:0] rd_data
);
  logic [NUM_WAYS-1:0] flags_q [NUM_SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) flags_q[s] <= '0;
    end else if (wr_en) begin
      flags_q[addr] <= wr_data;
    end
  end

  assign rd_data = flags_q[addr];
endmodule

// File: rtl/mru_flag_next.sv
module mru_flag_next #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] cur,
  input  logic [WAY_W-1:0]    way,
  output logic [NUM_WAYS-1:0] nxt
);
  logic [NUM_WAYS-1:0] hit_mask;
  logic [NUM_WAYS-1:0] base;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_mask
    assign hit_mask[g] = (way == WAY_W'(g));
  end

  assign base = (&cur) ? '0 : cur;
  assign nxt  = base | hit_mask;
endmodule

// File: rtl/mru_victim_enc.sv
module mru_victim_enc #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] flags,
  output logic [WAY_W-1:0]    victim
);
  always_comb begin
    victim = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!flags[i]) victim = WAY_W'(i);
    end
  end
endmodule

// File: rtl/mru_bit_replacer.sv
module mru_bit_replacer
  import mru_repl_pkg::*;
#(
  parameter int unsigned NUM_WAYS = DEF_WAYS,
  parameter int unsigned NUM_SETS = DEF_SETS,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS),
  localparam int unsigned SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SET_W-1:0]    set_idx,
  input  logic                acc_valid,
  input  logic [WAY_W-1:0]    acc_way,
  output logic [WAY_W-1:0]    victim_way,
  output logic [NUM_WAYS-1:0] set_flags
);
  logic [NUM_WAYS-1:0] cur_flags;
  logic [NUM_WAYS-1:0] upd_flags;

  mru_flag_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_store (
    .clk(clk), .rst(rst), .wr_en(acc_valid), .addr(set_idx),
    .wr_data(upd_flags), .rd_data(cur_flags)
  );

  mru_flag_next #(.NUM_WAYS(NUM_WAYS)) u_next (
    .cur(cur_flags), .way(acc_way), .nxt(upd_flags)
  );

  mru_victim_enc #(.NUM_WAYS(NUM_WAYS)) u_enc (
    .flags(cur_flags), .victim(victim_way)
  );

  assign set_flags = cur_flags;
endmodule

// File: rtl/mru_bit_replacer_chk.sv
module mru_bit_replacer_chk #(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS),
  localparam int unsigned SET_W = $clog2(NUM_SETS)
) (
  input logic                clk,
  input logic                rst,
  input logic [SET_W-1:0]    set_idx,
  input logic                acc_valid,
  input logic [WAY_W-1:0]    acc_way,
  input logic [WAY_W-1:0]    victim_way,
  input logic [NUM_WAYS-1:0] set_flags
);
  logic [NUM_WAYS-1:0] below_victim;
  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++) below_victim[i] = (WAY_W'(i) < victim_way);
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> set_flags == '0);

  // R2
  accessed_way_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_valid) && set_idx == $past(set_idx))
      |-> set_flags[$past(acc_way)]);

  // R3
  wrap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_valid) && (&$past(set_flags)) && set_idx == $past(set_idx))
      |-> $onehot0(set_flags) && set_flags[$past(acc_way)]);

  // R4
  victim_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (set_flags != '1) |-> !set_flags[victim_way] && ((~set_flags & below_victim) == '0));

  // R5
  victim_full_chk: assert property (@(posedge clk) disable iff (rst)
    (&set_flags) |-> victim_way == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(acc_valid) && set_idx == $past(set_idx)) |-> $stable(set_flags));
endmodule

bind mru_bit_replacer mru_bit_replacer_chk #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_chk (
  .clk(clk), .rst(rst), .set_idx(set_idx), .acc_valid(acc_valid), .acc_way(acc_way),
  .victim_way(victim_way), .set_flags(set_flags)
);

// File: tb/test_mru_bit_replacer.sv
module test_mru_bit_replacer;
  localparam int unsigned NW = 8;
  localparam int unsigned NS = 16;
  localparam int unsigned WW = $clog2(NW);
  localparam int unsigned SW = $clog2(NS);
  localparam int unsigned NROWS = 19;

  // row: {set[3:0], way[2:0], exp_flags[7:0], exp_victim[2:0]}
  localparam logic [17:0] VEC [NROWS] = '{
    {4'd3, 3'd0, 8'h01, 3'd1}, {4'd3, 3'd1, 8'h03, 3'd2},
    {4'd3, 3'd2, 8'h07, 3'd3}, {4'd3, 3'd3, 8'h0F, 3'd4},
    {4'd3, 3'd4, 8'h1F, 3'd5}, {4'd3, 3'd5, 8'h3F, 3'd6},
    {4'd3, 3'd6, 8'h7F, 3'd7}, {4'd3, 3'd7, 8'hFF, 3'd0},
    {4'd3, 3'd0, 8'h01, 3'd1},
    {4'd5, 3'd5, 8'h20, 3'd0}, {4'd5, 3'd0, 8'h21, 3'd1},
    {4'd5, 3'd2, 8'h25, 3'd1}, {4'd5, 3'd1, 8'h27, 3'd3},
    {4'd5, 3'd1, 8'h27, 3'd3}, {4'd5, 3'd7, 8'hA7, 3'd3},
    {4'd5, 3'd3, 8'hAF, 3'd4}, {4'd5, 3'd4, 8'hBF, 3'd6},
    {4'd5, 3'd6, 8'hFF, 3'd0}, {4'd5, 3'd3, 8'h08, 3'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] set_idx = '0;
  logic          acc_valid = 1'b0;
  logic [WW-1:0] acc_way = '0;
  logic [WW-1:0] victim_way;
  logic [NW-1:0] set_flags;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mru_bit_replacer #(.NUM_WAYS(NW), .NUM_SETS(NS)) i_mru_bit_replacer (
    .clk(clk), .rst(rst), .set_idx(set_idx), .acc_valid(acc_valid),
    .acc_way(acc_way), .victim_way(victim_way), .set_flags(set_flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [SW-1:0] s, input logic [WW-1:0] w);
    @(negedge clk);
    set_idx = s; acc_way = w; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic look(input logic [SW-1:0] s);
    set_idx = s;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of several sets
    for (int s = 0; s < NS; s += 5) begin
      look(SW'(s));
      check("R1 flags", 32'(set_flags), 32'h0);
      check("R1 victim", 32'(victim_way), 32'h0);
    end

    // vector table: R2 R3 R4 R5 R9
    for (int r = 0; r < NROWS; r++) begin
      access(VEC[r][17:14], VEC[r][13:11]);
      look(VEC[r][17:14]);
      check($sformatf("R2/R3/R9 flags row %0d", r), 32'(set_flags), 32'(VEC[r][10:3]));
      check($sformatf("R4/R5 victim row %0d", r), 32'(victim_way), 32'(VEC[r][2:0]));
    end

    // R7: other sets kept their state
    look(SW'(3));
    check("R7 set3", 32'(set_flags), 32'h01);
    look(SW'(0));
    check("R7 set0", 32'(set_flags), 32'h00);

    // R8: idle cycles with a changing way do nothing
    @(negedge clk);
    set_idx = SW'(5);
    for (int i = 0; i < 4; i++) begin
      acc_way = WW'(i);
      @(negedge clk);
    end
    check("R8 idle", 32'(set_flags), 32'h08);

    // R6: old value before the edge, new value after
    @(negedge clk);
    set_idx = SW'(5); acc_way = WW'(6); acc_valid = 1'b1;
    #1;
    check("R6 before edge", 32'(set_flags), 32'h08);
    @(negedge clk);
    acc_valid = 1'b0;
    check("R6 after edge", 32'(set_flags), 32'h48);

    // R3 boundary: partial set filled to all ones does not clear early
    for (int w = 1; w < NW; w++) access(SW'(7), WW'(w));
    look(SW'(7));
    check("R4 victim way0 last", 32'(victim_way), 32'h0);
    access(SW'(7), WW'(0));
    look(SW'(7));
    check("R3 no early clear", 32'(set_flags), 32'hFF);
    check("R5 full victim", 32'(victim_way), 32'h0);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    look(SW'(7));
    check("R1 mid-run reset", 32'(set_flags), 32'h0);
    look(SW'(5));
    check("R1 mid-run reset set5", 32'(set_flags), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule